// File: doc/BRIEF.md
# Processor Status Flag Unit

This block holds the seven condition and mode flags of an 8-bit processor core. It takes N and Z from any result byte the datapath reports: loads, register transfers, increment and decrement, and the logical OR, AND and XOR. It accepts carry and overflow values from the arithmetic unit as external update inputs. It carries out explicit set and clear flag operations. It packs the flags into a status byte for saving on the stack, and it unpacks a status byte on restore, for example on return from interrupt.

The same register set feeds a branch condition evaluator. The core presents a condition code and reads back a taken signal in the same cycle. Cycles that raise no strobe, such as a move of X into the stack pointer, leave every flag untouched.

Top module: `psw_flag_unit`

## Requirements
- R1: After the active-low asynchronous reset, status_o reads 0x04. Only the interrupt mask is set, and carry_o, dec_mode_o and index_mode_o are 0.
- R2: The status byte layout is: bit7 N, bit6 V, bit5 index mode T, bit3 D (decimal), bit2 I (interrupt mask), bit1 Z, bit0 C. Bit 4 always reads 0.
- R3: When nz_upd_i is high, the flags on the next cycle have N equal to result_i[7] and Z equal to 1 exactly when result_i is zero. No other flag changes.
- R4: flag_op_i codes: 1 clears C, 2 sets C, 3 clears D, 4 sets D, 5 clears I, 6 sets I, 7 clears T, 8 sets T. The change shows one cycle later.
- R5: Code 9 clears V. No code sets V. Codes 0 and 10 to 15 change no flag.
- R6: sr_load_i high loads all seven flags from the matching bits of sr_data_i. Bit 4 of the data is ignored, so status_o next cycle equals sr_data_i with bit 4 cleared.
- R7: A status load wins over nz_upd_i, c_upd_i, v_upd_i and flag_op_i in the same cycle. All of those are discarded.
- R8: c_upd_i loads C from c_i and v_upd_i loads V from v_i. A flag operation on C or V in the same cycle wins over the external value.
- R9: br_taken_o depends combinationally on br_cond_i and the current flags. The codes are: 0 taken if N=0, 1 if N=1, 2 if Z=1, 3 if Z=0, 4 if C=1, 5 if C=0, 6 if V=1, 7 if V=0, and 8 always.
- R10: br_cond_i codes 9 to 15 never signal taken.
- R11: A cycle with no strobe and flag_op_i 0 leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 8 | Result byte used for N and Z |
| nz_upd_i | input | 1 | Update N and Z from result_i |
| c_upd_i | input | 1 | Update C from c_i |
| c_i | input | 1 | External carry value |
| v_upd_i | input | 1 | Update V from v_i |
| v_i | input | 1 | External overflow value |
| flag_op_i | input | 4 | Flag set or clear operation code |
| sr_load_i | input | 1 | Load all flags from sr_data_i |
| sr_data_i | input | 8 | Status byte to restore |
| br_cond_i | input | 4 | Branch condition code |
| status_o | output | 8 | Packed status byte |
| carry_o | output | 1 | Carry flag |
| dec_mode_o | output | 1 | Decimal mode flag |
| irq_mask_o | output | 1 | Interrupt mask flag |
| index_mode_o | output | 1 | Index mode flag |
| br_taken_o | output | 1 | Branch condition met |

## Verification
Every flag change is registered. A strobe driven before a rising edge therefore shows on status_o and the mode outputs right after that edge. The driver pushes the expected status byte into a queue once that edge has passed. The monitor pops it and compares at the following falling edge. br_taken_o has no register in its path, so the driver checks it one nanosecond after it drives the condition code, in the same cycle. All 256 status values go through a load and read-back with bit 4 masked. Each strobe pairing that the priority rules cover is driven in a single cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int SR_W  = 8;
  localparam int POS_N = 7;
  localparam int POS_V = 6;
  localparam int POS_T = 5;
  localparam int POS_D = 3;
  localparam int POS_I = 2;
  localparam int POS_Z = 1;
  localparam int POS_C = 0;

  typedef enum logic [3:0] {
    FOP_NONE = 4'd0,
    FOP_CLC  = 4'd1,
    FOP_SEC  = 4'd2,
    FOP_CLD  = 4'd3,
    FOP_SED  = 4'd4,
    FOP_CLI  = 4'd5,
    FOP_SEI  = 4'd6,
    FOP_CLT  = 4'd7,
    FOP_SETT = 4'd8,
    FOP_CLV  = 4'd9
  } flag_op_e;

  typedef enum logic [3:0] {
    BC_PL = 4'd0,
    BC_MI = 4'd1,
    BC_EQ = 4'd2,
    BC_NE = 4'd3,
    BC_CS = 4'd4,
    BC_CC = 4'd5,
    BC_VS = 4'd6,
    BC_VC = 4'd7,
    BC_AL = 4'd8
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic v;
    logic t;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RST = '{n: 1'b0, v: 1'b0, t: 1'b0, d: 1'b0,
                                   i: 1'b1, z: 1'b0, c: 1'b0};
endpackage

// File: rtl/psw_pack.sv
module psw_pack
  import psw_pkg::*;
(
  input  flags_t            flags_i,
  output logic [SR_W-1:0]   sr_o
);
  always_comb begin
    sr_o        = '0;
    sr_o[POS_N] = flags_i.n;
    sr_o[POS_V] = flags_i.v;
    sr_o[POS_T] = flags_i.t;
    sr_o[POS_D] = flags_i.d;
    sr_o[POS_I] = flags_i.i;
    sr_o[POS_Z] = flags_i.z;
    sr_o[POS_C] = flags_i.c;
  end
endmodule

// File: rtl/psw_unpack.sv
module psw_unpack
  import psw_pkg::*;
(
  input  logic [SR_W-1:0] sr_i,
  output flags_t          flags_o
);
  logic unused_bit4;
  assign unused_bit4 = sr_i[4];

  always_comb begin
    flags_o.n = sr_i[POS_N];
    flags_o.v = sr_i[POS_V];
    flags_o.t = sr_i[POS_T];
    flags_o.d = sr_i[POS_D];
    flags_o.i = sr_i[POS_I];
    flags_o.z = sr_i[POS_Z];
    flags_o.c = sr_i[POS_C];
  end
endmodule

// File: rtl/psw_branch.sv
module psw_branch
  import psw_pkg::*;
(
  input  br_cond_e cond_i,
  input  flags_t   flags_i,
  output logic     taken_o
);
  always_comb begin
    case (cond_i)
      BC_PL:   taken_o = ~flags_i.n;
      BC_MI:   taken_o =  flags_i.n;
      BC_EQ:   taken_o =  flags_i.z;
      BC_NE:   taken_o = ~flags_i.z;
      BC_CS:   taken_o =  flags_i.c;
      BC_CC:   taken_o = ~flags_i.c;
      BC_VS:   taken_o =  flags_i.v;
      BC_VC:   taken_o = ~flags_i.v;
      BC_AL:   taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end

  always_comb begin
    if (cond_i == BC_AL) p_always_taken_r9: assert (taken_o);
    if (cond_i > BC_AL)  p_undef_never_r10: assert (!taken_o);
  end
endmodule

// File: rtl/psw_regs.sv
module psw_regs
  import psw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] result_i,
  input  logic          nz_upd_i,
  input  logic          c_upd_i,
  input  logic          c_i,
  input  logic          v_upd_i,
  input  logic          v_i,
  input  flag_op_e      op_i,
  input  logic          load_i,
  input  flags_t        load_flags_i,
  output flags_t        flags_o
);
  localparam int MSB = DW - 1;

  flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load_i) begin
      flags_d = load_flags_i;
    end else begin
      if (nz_upd_i) begin
        flags_d.n = result_i[MSB];
        flags_d.z = ~|result_i;
      end
      if (c_upd_i) flags_d.c = c_i;
      if (v_upd_i) flags_d.v = v_i;
      // explicit ops override the arithmetic C/V values
      case (op_i)
        FOP_CLC:  flags_d.c = 1'b0;
        FOP_SEC:  flags_d.c = 1'b1;
        FOP_CLD:  flags_d.d = 1'b0;
        FOP_SED:  flags_d.d = 1'b1;
        FOP_CLI:  flags_d.i = 1'b0;
        FOP_SEI:  flags_d.i = 1'b1;
        FOP_CLT:  flags_d.t = 1'b0;
        FOP_SETT: flags_d.t = 1'b1;
        FOP_CLV:  flags_d.v = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= FLAGS_RST;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flags_q == $past(load_flags_i));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !nz_upd_i && !c_upd_i && !v_upd_i && op_i == FOP_NONE) |=> $stable(flags_q));

  p_z_tracks_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nz_upd_i && !load_i) |=> flags_q.z == ($past(result_i) == '0));

  p_clv_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && op_i == FOP_CLV) |=> !flags_q.v);
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] result_i,
  input  logic          nz_upd_i,
  input  logic          c_upd_i,
  input  logic          c_i,
  input  logic          v_upd_i,
  input  logic          v_i,
  input  logic [3:0]    flag_op_i,
  input  logic          sr_load_i,
  input  logic [7:0]    sr_data_i,
  input  logic [3:0]    br_cond_i,
  output logic [7:0]    status_o,
  output logic          carry_o,
  output logic          dec_mode_o,
  output logic          irq_mask_o,
  output logic          index_mode_o,
  output logic          br_taken_o
);
  flags_t load_flags, flags;

  psw_unpack u_unpack (
    .sr_i    (sr_data_i),
    .flags_o (load_flags)
  );

  psw_regs #(.DW(DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .result_i     (result_i),
    .nz_upd_i     (nz_upd_i),
    .c_upd_i      (c_upd_i),
    .c_i          (c_i),
    .v_upd_i      (v_upd_i),
    .v_i          (v_i),
    .op_i         (flag_op_e'(flag_op_i)),
    .load_i       (sr_load_i),
    .load_flags_i (load_flags),
    .flags_o      (flags)
  );

  psw_pack u_pack (
    .flags_i (flags),
    .sr_o    (status_o)
  );

  psw_branch u_branch (
    .cond_i  (br_cond_e'(br_cond_i)),
    .flags_i (flags),
    .taken_o (br_taken_o)
  );

  assign carry_o      = flags.c;
  assign dec_mode_o   = flags.d;
  assign irq_mask_o   = flags.i;
  assign index_mode_o = flags.t;

  p_restore_roundtrip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_i |=> status_o == ($past(sr_data_i) & 8'hEF));
endmodule

// File: tb/tb_psw_flag_unit.sv
`timescale 1ns/1ps
module tb_psw_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] result = '0;
  logic       nz_upd = 1'b0, c_upd = 1'b0, c_val = 1'b0, v_upd = 1'b0, v_val = 1'b0;
  logic [3:0] flag_op = '0;
  logic       sr_load = 1'b0;
  logic [7:0] sr_data = '0;
  logic [3:0] br_cond = '0;
  logic [7:0] status;
  logic       carry, dec_mode, irq_mask, index_mode, br_taken;

  int total = 0;
  int passed = 0;
  bit done = 1'b0;
  logic [7:0] model_sr;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  psw_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result), .nz_upd_i(nz_upd),
    .c_upd_i(c_upd), .c_i(c_val), .v_upd_i(v_upd), .v_i(v_val),
    .flag_op_i(flag_op), .sr_load_i(sr_load), .sr_data_i(sr_data),
    .br_cond_i(br_cond), .status_o(status), .carry_o(carry),
    .dec_mode_o(dec_mode), .irq_mask_o(irq_mask), .index_mode_o(index_mode),
    .br_taken_o(br_taken)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
  endtask

  function automatic logic br_model(input logic [7:0] s, input logic [3:0] bc);
    case (bc)
      4'd0: return ~s[7];
      4'd1: return  s[7];
      4'd2: return  s[1];
      4'd3: return ~s[1];
      4'd4: return  s[0];
      4'd5: return ~s[0];
      4'd6: return  s[6];
      4'd7: return ~s[6];
      4'd8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] next_model(input logic [7:0] s0, input logic nz,
      input logic [7:0] res, input logic cu, input logic c, input logic vu,
      input logic v, input logic [3:0] op, input logic ld, input logic [7:0] d);
    logic [7:0] s;
    if (ld) return d & 8'hEF;
    s = s0;
    if (nz) begin s[7] = res[7]; s[1] = (res == 8'h00); end
    if (cu) s[0] = c;
    if (vu) s[6] = v;
    case (op)
      4'd1: s[0] = 1'b0;
      4'd2: s[0] = 1'b1;
      4'd3: s[3] = 1'b0;
      4'd4: s[3] = 1'b1;
      4'd5: s[2] = 1'b0;
      4'd6: s[2] = 1'b1;
      4'd7: s[5] = 1'b0;
      4'd8: s[5] = 1'b1;
      4'd9: s[6] = 1'b0;
      default: ;
    endcase
    return s;
  endfunction

  // driver: branch checked same cycle, status expectation queued after the edge
  task automatic step(input logic nz, input logic [7:0] res, input logic cu,
      input logic c, input logic vu, input logic v, input logic [3:0] op,
      input logic ld, input logic [7:0] d, input logic [3:0] bc, input string tag);
    @(negedge clk);
    nz_upd = nz; result = res; c_upd = cu; c_val = c; v_upd = vu; v_val = v;
    flag_op = op; sr_load = ld; sr_data = d; br_cond = bc;
    #1;
    chk($sformatf("R9 R10 branch cond=%0d", bc), {7'd0, br_taken}, {7'd0, br_model(model_sr, bc)});
    @(posedge clk);
    model_sr = next_model(model_sr, nz, res, cu, c, vu, v, op, ld, d);
    exp_q.push_back(model_sr);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 8'h00, 4'd8, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " status"}, status, e);
      chk({t, " R2 mode outputs"}, {4'd0, index_mode, dec_mode, irq_mask, carry},
          {4'd0, e[5], e[3], e[2], e[0]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    model_sr = 8'h04;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset status", status, 8'h04);
    chk("R1 reset modes", {4'd0, index_mode, dec_mode, irq_mask, carry}, 8'h02);
    rst_n = 1'b1;

    idle("R11 idle hold");
    // R3 N/Z from results
    step(1'b1, 8'h00, 0, 0, 0, 0, 4'd0, 0, 8'h00, 4'd2, "R3 zero result");
    step(1'b1, 8'h80, 0, 0, 0, 0, 4'd0, 0, 8'h00, 4'd1, "R3 negative result");
    step(1'b1, 8'h35, 0, 0, 0, 0, 4'd0, 0, 8'h00, 4'd3, "R3 positive result");
    // R4 set then clear each mode/carry flag
    for (int op = 2; op <= 8; op += 2)
      step(0, 8'h00, 0, 0, 0, 0, 4'(op), 0, 8'h00, 4'd4, $sformatf("R4 set op=%0d", op));
    idle("R11 hold after sets");
    for (int op = 1; op <= 7; op += 2)
      step(0, 8'h00, 0, 0, 0, 0, 4'(op), 0, 8'h00, 4'd5, $sformatf("R4 clear op=%0d", op));
    // R8 external C/V
    step(0, 8'h00, 1, 1, 1, 1, 4'd0, 0, 8'h00, 4'd6, "R8 external C V set");
    step(0, 8'h00, 1, 1, 0, 0, 4'd1, 0, 8'h00, 4'd4, "R8 CLC beats c_upd");
    // R5 CLV and undefined ops
    step(0, 8'h00, 0, 0, 1, 1, 4'd9, 0, 8'h00, 4'd7, "R5 R8 CLV beats v_upd");
    step(0, 8'h00, 0, 0, 0, 0, 4'd0, 1, 8'hFF, 4'd0, "R6 load all ones");
    for (int op = 10; op <= 15; op++)
      step(0, 8'h00, 0, 0, 0, 0, 4'(op), 0, 8'h00, 4'd6, $sformatf("R5 unassigned op=%0d", op));
    // R7 load priority
    step(1, 8'h00, 1, 1, 1, 1, 4'd2, 1, 8'h00, 4'd8, "R7 load beats all updates");
    step(1, 8'h00, 0, 0, 0, 0, 4'd8, 1, 8'hC3, 4'd8, "R7 load beats nz and SET T");
    // R9/R10 every condition code against several flag states
    foreach (sr_pat[k]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pat;
      pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hC3 : (k == 2) ? 8'h41 : 8'h82;
      step(0, 8'h00, 0, 0, 0, 0, 4'd0, 1, pat, 4'd8, "R6 load for branch sweep");
      for (int bc = 0; bc < 16; bc++)
        step(0, 8'h00, 0, 0, 0, 0, 4'd0, 0, 8'h00, 4'(bc), "R9 R10 R11 sweep hold");
    end
    // R6/R2 round trip of every status byte
    for (int v = 0; v < 256; v++)
      step(0, 8'h00, 0, 0, 0, 0, 4'd0, 1, 8'(v), 4'(v % 16), "R6 R2 round trip");
    idle("R11 final hold");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  logic [1:0] sr_pat [2];
endmodule